// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host side of an asynchronous NOR-flash style bus and turns host write cycles into operation requests. The chip-enable and write-enable lines are brought into the system clock domain through two-stage synchronisers. An edge detector marks where each write cycle opens and closes. The address is captured when the cycle opens and the data when it closes, and one strobe per completed write goes to a sequence state machine.

The state machine checks the unlock pattern and the command codes, and on a complete command it issues a one-cycle request to the operation engine together with the captured address and data. It reports the current mode (read, identifier, erase-suspended or busy), and an engine completion pulse returns it from a running operation. Additional sector addresses for an erase are collected inside a programmable window, and erasing starts when the window closes with no further address. Word and byte addressing use different unlock addresses, selected by a static input.

The state machine has these states. READ is the idle array-read state. UNLK1 and UNLK2 follow the first and the second unlock cycles. PRG_ARG waits for the program address and data. ERS_CMD follows the erase set-up code, and ERS_UNLK1 and ERS_UNLK2 follow the second unlock pair. SEC_WIN collects sector addresses. ID is the identifier mode and SUSP the erase-suspended mode. RUN_PRG, RUN_CHIP and RUN_SEC mark a running program, chip erase or sector erase.

The transitions are these. Unlock advance moves READ or SUSP to UNLK1 and then to UNLK2. Command dispatch moves UNLK2 to PRG_ARG, ID or ERS_CMD. Program launch moves PRG_ARG to RUN_PRG. The second unlock moves ERS_CMD through ERS_UNLK1 to ERS_UNLK2. Chip launch moves ERS_UNLK2 to RUN_CHIP. Sector collect moves ERS_UNLK2 to SEC_WIN and keeps SEC_WIN in SEC_WIN. Window expiry moves SEC_WIN to RUN_SEC. Suspend moves RUN_SEC to SUSP, and resume moves SUSP to RUN_SEC. Abort returns a sequence state to its home, READ or SUSP. ID exit moves ID to its home. Completion moves a RUN state to its home.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is counted only when chip-enable and write-enable are both low and output-enable is high as the cycle closes. The address is taken when the cycle opens, so later address changes have no effect. The data is taken when the cycle closes.
- R2: With byte_mode=0 the unlock cycles are 0xAA at address 0x555 and then 0x55 at 0x2AA, compared on address bits [10:0]. With byte_mode=1 they are 0xAA at 0xAAA and then 0x55 at 0x555, compared on bits [11:0].
- R3: The two unlock cycles, then 0xA0 at the first unlock address, then one write, pulse req_program with that write's address and full 16-bit data. Mode stays busy until eng_done.
- R4: Unlock, 0x80, unlock, then 0x10 at the first unlock address pulse req_chip_erase, and mode becomes busy. If 0x10 is written to any other address, the decoder returns to read.
- R5: In the same sequence, 0x30 at any address pulses req_sector with that address and opens a window of WIN_CYC cycles. A further 0x30 inside the window pulses req_sector again and restarts the window. On expiry req_erase_start pulses and mode becomes busy. Any other write inside the window aborts to read with no erase start.
- R6: Unlock followed by 0x90 at the first unlock address enters the identifier mode. There only a 0xF0 write has an effect: it leaves to the mode the sequence began from.
- R7: A single 0xF0 write at any address, or the unlocked three-cycle form ending in 0xF0, returns the decoder to its home mode.
- R8: A wrong address or data in any sequence cycle, or 0xF0 written part-way, returns the decoder to read, or to erase-suspend if the sequence began there.
- R9: 0xB0 pulses req_suspend and enters erase-suspend only while a sector erase runs. During a program or chip erase every write is ignored. The erase set-up code 0x80 from erase-suspend is refused.
- R10: A single 0x30 write pulses req_resume and returns to the running sector erase only from erase-suspend. Elsewhere it has no effect.
- R11: A program or identifier sequence started in erase-suspend returns to erase-suspend when it completes or exits.
- R12: Bits [15:8] of the data are ignored in unlock and command cycles.
- R13: mode encodes 0 read, 1 identifier, 2 erase-suspend, 3 busy. After reset it is 0 and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte addressing for unlock compares |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_dq | input | DATA_W | Bus write data |
| eng_done | input | 1 | Engine pulse: running operation finished |
| mode | output | 2 | Current mode (see R13) |
| req_program | output | 1 | One-cycle program request |
| req_chip_erase | output | 1 | One-cycle chip erase request |
| req_sector | output | 1 | One-cycle sector address request |
| req_erase_start | output | 1 | One-cycle sector erase start |
| req_suspend | output | 1 | One-cycle erase suspend request |
| req_resume | output | 1 | One-cycle erase resume request |
| req_addr | output | ADDR_W | Address captured with the last program or sector request |
| req_data | output | DATA_W | Data captured with the last program or sector request |

## Verification
A write's request pulse and its mode change are due on the fourth rising clock edge after the enables rise. The bench updates its expected mode at that edge and counts request pulses at the falling edge that follows. An eng_done pulse takes effect on the next edge. Erase start falls exactly WIN_CYC edges after the edge that carried the last sector request, so the bench waits that many edges before expecting busy. The mode is compared against the reference on every falling edge of the clock.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_PRG_ARG,
        ST_ERS_CMD,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_SEC_WIN,
        ST_ID,
        ST_SUSP,
        ST_RUN_PRG,
        ST_RUN_CHIP,
        ST_RUN_SEC
    } fcd_state_t;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_ID   = 2'd1,
        MODE_SUSP = 2'd2,
        MODE_BUSY = 2'd3
    } fcd_mode_t;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic start;
        logic susp;
        logic resume;
    } fcd_req_t;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_RESET  = 8'hF0;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_IDENT  = 8'h90;
    localparam logic [7:0] CODE_SUSP   = 8'hB0;

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] ce_sync;
    logic [SYNC_N-1:0] we_sync;
    logic              act_q;
    logic              act_now;
    logic              opens;
    logic              closes;

    assign act_now = !ce_sync[SYNC_N-1] && !we_sync[SYNC_N-1];
    assign opens   = act_now && !act_q;
    assign closes  = !act_now && act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_sync <= '1;
            we_sync <= '1;
            act_q   <= 1'b0;
        end else begin
            ce_sync <= {ce_sync[SYNC_N-2:0], ce_n};
            we_sync <= {we_sync[SYNC_N-2:0], we_n};
            act_q   <= act_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= closes && oe_n;
            if (opens)  wr_addr <= addr;
            if (closes) wr_data <= dq;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);                                   // R1
    AST_STB_NEEDS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(act_q));                              // R1

endmodule

// File: rtl/fcd_win_timer.sv
module fcd_win_timer #(
    parameter int WIN_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] TOP = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= TOP;
        else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && !load && (cnt_q == '0);

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);                                         // R5
    AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == TOP);                                // R5

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11,
    parameter logic [CMP_W-1:0] KEY1_WORD = 'h555,
    parameter logic [CMP_W-1:0] KEY2_WORD = 'h2AA,
    parameter logic [CMP_W:0]   KEY1_BYTE = 'hAAA,
    parameter logic [CMP_W:0]   KEY2_BYTE = 'h555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_done,
    input  logic              win_expired,
    output logic              win_load,
    output logic              win_run,
    output logic [1:0]        mode,
    output logic              req_program,
    output logic              req_chip_erase,
    output logic              req_sector,
    output logic              req_erase_start,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);

    fcd_state_t state_q, nxt_state, home;
    logic       from_susp_q, nxt_from;
    fcd_req_t   nxt_req;
    fcd_mode_t  mode_c;
    logic       hit1, hit2;
    logic [7:0] cmd;

    assign cmd = wr_data[7:0];

    always_comb begin
        if (byte_mode) begin
            hit1 = (wr_addr[CMP_W:0] == KEY1_BYTE);
            hit2 = (wr_addr[CMP_W:0] == KEY2_BYTE);
        end else begin
            hit1 = (wr_addr[CMP_W-1:0] == KEY1_WORD);
            hit2 = (wr_addr[CMP_W-1:0] == KEY2_WORD);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_READ;
            from_susp_q <= 1'b0;
        end else begin
            state_q     <= nxt_state;
            from_susp_q <= nxt_from;
        end
    end

    // transitions
    always_comb begin
        nxt_state = state_q;
        nxt_from  = from_susp_q;
        nxt_req   = '0;
        win_load  = 1'b0;
        home      = from_susp_q ? ST_SUSP : ST_READ;
        unique case (state_q)
            ST_READ: begin
                if (wr_stb && hit1 && cmd == CODE_KEY1) begin
                    nxt_state = ST_UNLK1;
                    nxt_from  = 1'b0;
                end
            end
            ST_SUSP: begin
                if (wr_stb) begin
                    if (hit1 && cmd == CODE_KEY1) begin
                        nxt_state = ST_UNLK1;
                        nxt_from  = 1'b1;
                    end else if (cmd == CODE_SECT) begin
                        nxt_state      = ST_RUN_SEC;
                        nxt_req.resume = 1'b1;
                    end
                end
            end
            ST_UNLK1: begin
                if (wr_stb)
                    nxt_state = (hit2 && cmd == CODE_KEY2) ? ST_UNLK2 : home;
            end
            ST_UNLK2: begin
                if (wr_stb) begin
                    nxt_state = home;
                    if (hit1) begin
                        if (cmd == CODE_PROG)
                            nxt_state = ST_PRG_ARG;
                        else if (cmd == CODE_IDENT)
                            nxt_state = ST_ID;
                        else if (cmd == CODE_ERASE && !from_susp_q)
                            nxt_state = ST_ERS_CMD;
                    end
                end
            end
            ST_PRG_ARG: begin
                if (wr_stb) begin
                    if (cmd == CODE_RESET) begin
                        nxt_state = home;
                    end else begin
                        nxt_state    = ST_RUN_PRG;
                        nxt_req.prog = 1'b1;
                    end
                end
            end
            ST_ERS_CMD: begin
                if (wr_stb)
                    nxt_state = (hit1 && cmd == CODE_KEY1) ? ST_ERS_UNLK1 : ST_READ;
            end
            ST_ERS_UNLK1: begin
                if (wr_stb)
                    nxt_state = (hit2 && cmd == CODE_KEY2) ? ST_ERS_UNLK2 : ST_READ;
            end
            ST_ERS_UNLK2: begin
                if (wr_stb) begin
                    nxt_state = ST_READ;
                    if (hit1 && cmd == CODE_CHIP) begin
                        nxt_state    = ST_RUN_CHIP;
                        nxt_req.chip = 1'b1;
                    end else if (cmd == CODE_SECT) begin
                        nxt_state    = ST_SEC_WIN;
                        nxt_req.sect = 1'b1;
                        win_load     = 1'b1;
                    end
                end
            end
            ST_SEC_WIN: begin
                if (wr_stb) begin
                    if (cmd == CODE_SECT) begin
                        nxt_req.sect = 1'b1;
                        win_load     = 1'b1;
                    end else begin
                        nxt_state = ST_READ;
                    end
                end else if (win_expired) begin
                    nxt_state     = ST_RUN_SEC;
                    nxt_req.start = 1'b1;
                end
            end
            ST_ID: begin
                if (wr_stb && cmd == CODE_RESET) nxt_state = home;
            end
            ST_RUN_PRG: begin
                if (eng_done) nxt_state = home;
            end
            ST_RUN_CHIP: begin
                if (eng_done) nxt_state = ST_READ;
            end
            ST_RUN_SEC: begin
                if (eng_done) begin
                    nxt_state = ST_READ;
                end else if (wr_stb && cmd == CODE_SUSP) begin
                    nxt_state    = ST_SUSP;
                    nxt_req.susp = 1'b1;
                end
            end
            default: nxt_state = ST_READ;
        endcase
    end

    assign win_run = (state_q == ST_SEC_WIN);

    // mode decode
    always_comb begin
        unique case (state_q)
            ST_UNLK1, ST_UNLK2, ST_PRG_ARG:
                mode_c = from_susp_q ? MODE_SUSP : MODE_READ;
            ST_ID:   mode_c = MODE_ID;
            ST_SUSP: mode_c = MODE_SUSP;
            ST_RUN_PRG, ST_RUN_CHIP, ST_RUN_SEC:
                mode_c = MODE_BUSY;
            default: mode_c = MODE_READ;
        endcase
    end
    assign mode = mode_c;

    // request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_program     <= 1'b0;
            req_chip_erase  <= 1'b0;
            req_sector      <= 1'b0;
            req_erase_start <= 1'b0;
            req_suspend     <= 1'b0;
            req_resume      <= 1'b0;
            req_addr        <= '0;
            req_data        <= '0;
        end else begin
            req_program     <= nxt_req.prog;
            req_chip_erase  <= nxt_req.chip;
            req_sector      <= nxt_req.sect;
            req_erase_start <= nxt_req.start;
            req_suspend     <= nxt_req.susp;
            req_resume      <= nxt_req.resume;
            if (nxt_req.prog || nxt_req.sect) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end
        end
    end

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_program, req_chip_erase, req_sector,
                  req_erase_start, req_suspend, req_resume}));  // R3
    AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_program |-> mode == MODE_BUSY);                     // R3
    AST_SUSP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        req_suspend |-> $past(state_q) == ST_RUN_SEC);          // R9
    AST_RESUME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume |-> $past(state_q) == ST_SUSP);              // R10
    AST_START_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        req_erase_start |-> $past(win_run));                    // R5
    AST_CHIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_CHIP && !eng_done) |=> state_q == ST_RUN_CHIP); // R9

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int CMP_W   = 11,
    parameter int WIN_CYC = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_dq,
    input  logic              eng_done,
    output logic [1:0]        mode,
    output logic              req_program,
    output logic              req_chip_erase,
    output logic              req_sector,
    output logic              req_erase_start,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              win_load, win_run, win_expired;

    fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
        .addr(bus_addr), .dq(bus_dq),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fcd_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n),
        .load(win_load), .run(win_run), .expired(win_expired)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_done(eng_done), .win_expired(win_expired),
        .win_load(win_load), .win_run(win_run), .mode(mode),
        .req_program(req_program), .req_chip_erase(req_chip_erase),
        .req_sector(req_sector), .req_erase_start(req_erase_start),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .req_addr(req_addr), .req_data(req_data)
    );

endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

    localparam int AW  = 19;
    localparam int DW  = 16;
    localparam int WIN = 40;
    // pulse kinds
    localparam int K_NONE = 0, K_PRG = 1, K_CHIP = 2, K_SECT = 3,
                   K_START = 4, K_SUSP = 5, K_RES = 6;
    localparam int M_READ = 0, M_ID = 1, M_SUSP = 2, M_BUSY = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_mode = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq = '0;
    logic          eng_done = 1'b0;
    logic [1:0]    mode;
    logic          r_prg, r_chip, r_sect, r_start, r_susp, r_res;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_data;

    int checks = 0;
    int errors = 0;
    int exp_mode = M_READ;
    int pc[7];
    int cyc = 0;
    bit finished = 0;
    bit late_en = 0;
    logic [AW-1:0] late_addr = '0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .WIN_CYC(WIN)) u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_dq(dq), .eng_done(eng_done),
        .mode(mode),
        .req_program(r_prg), .req_chip_erase(r_chip), .req_sector(r_sect),
        .req_erase_start(r_start), .req_suspend(r_susp), .req_resume(r_res),
        .req_addr(r_addr), .req_data(r_data)
    );

    // reference compare every clock (R13 mode encoding)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            pc[K_PRG]   += int'(r_prg);
            pc[K_CHIP]  += int'(r_chip);
            pc[K_SECT]  += int'(r_sect);
            pc[K_START] += int'(r_start);
            pc[K_SUSP]  += int'(r_susp);
            pc[K_RES]   += int'(r_res);
            checks++;
            if (int'(mode) != exp_mode) begin
                errors++;
                $display("FAIL R13 mode actual %0d expected %0d at %0t", mode, exp_mode, $time);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic void check_pulses(input int base[7], input int kind, input string tag);
        checks++;
        for (int k = 1; k < 7; k++) begin
            int want = (k == kind) ? 1 : 0;
            if (pc[k] - base[k] != want) begin
                errors++;
                $display("FAIL %s pulse kind %0d actual %0d expected %0d", tag, k, pc[k] - base[k], want);
            end
        end
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int m, input int kind, input string tag);
        int base[7];
        base = pc;
        @(negedge clk);
        addr = a; dq = d; ce_n = 1'b0; we_n = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (i == 3 && late_en) addr = late_addr;
        end
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(posedge clk);
        exp_mode = m;
        @(negedge clk);
        @(posedge clk);
        check_pulses(base, kind, tag);
        if (kind == K_PRG || kind == K_SECT) begin
            checks++;
            if (r_addr !== a || r_data !== d) begin
                errors++;
                $display("FAIL %s addr/data actual %h/%h expected %h/%h", tag, r_addr, r_data, a, d);
            end
        end
        late_en = 0;
        @(negedge clk);
    endtask

    task automatic done_pulse(input int m);
        @(negedge clk);
        eng_done = 1'b1;
        @(posedge clk);
        exp_mode = m;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic unlock(input int m, input string tag);
        if (byte_mode) begin
            wr(19'hAAA, 16'h00AA, m, K_NONE, tag);
            wr(19'h555, 16'h0055, m, K_NONE, tag);
        end else begin
            wr(19'h555, 16'h00AA, m, K_NONE, tag);
            wr(19'h2AA, 16'h0055, m, K_NONE, tag);
        end
    endtask

    initial begin
        int base[7];
        for (int k = 0; k < 7; k++) pc[k] = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        checks++;
        if (mode !== 2'd0 || {r_prg, r_chip, r_sect, r_start, r_susp, r_res} !== 6'b0) begin
            errors++;
            $display("FAIL R13 reset actual mode %0d expected 0", mode);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 + R1: program, address moves after the cycle opens
        unlock(M_READ, "R3 unlock");
        wr(19'h00555, 16'h00A0, M_READ, K_NONE, "R3 setup");
        late_en = 1; late_addr = 19'h00777;
        wr(19'h12345, 16'h1234, M_BUSY, K_PRG, "R3 R1 program");
        wr(19'h00000, 16'h00F0, M_BUSY, K_NONE, "R9 ignored during program");
        done_pulse(M_READ);

        // R1: write with output enable low is not counted
        oe_n = 1'b0;
        wr(19'h555, 16'h00AA, M_READ, K_NONE, "R1 oe low");
        oe_n = 1'b1;
        wr(19'h2AA, 16'h0055, M_READ, K_NONE, "R1 after oe low");
        wr(19'h555, 16'h00A0, M_READ, K_NONE, "R1 no setup");
        wr(19'h00100, 16'h0001, M_READ, K_NONE, "R1 no program");

        // R2: byte mode addresses, and byte addresses rejected in word mode
        byte_mode = 1'b1;
        unlock(M_READ, "R2 byte unlock");
        wr(19'h00AAA, 16'h00A0, M_READ, K_NONE, "R2 byte setup");
        wr(19'h40001, 16'hBEEF, M_BUSY, K_PRG, "R2 byte program");
        done_pulse(M_READ);
        byte_mode = 1'b0;
        wr(19'hAAA, 16'h00AA, M_READ, K_NONE, "R2 word rejects byte key");
        wr(19'h555, 16'h0055, M_READ, K_NONE, "R2 word rejects");
        wr(19'h555, 16'h00A0, M_READ, K_NONE, "R2 word rejects");
        wr(19'h00200, 16'h0002, M_READ, K_NONE, "R2 no program");

        // R12: upper data bits ignored in unlock/command cycles
        wr(19'h555, 16'hFFAA, M_READ, K_NONE, "R12 unlock1");
        wr(19'h2AA, 16'h3355, M_READ, K_NONE, "R12 unlock2");
        wr(19'h555, 16'h77A0, M_READ, K_NONE, "R12 setup");
        wr(19'h00300, 16'hA5A5, M_BUSY, K_PRG, "R12 program");
        done_pulse(M_READ);

        // R4 chip erase, R9 suspend refused
        unlock(M_READ, "R4");
        wr(19'h555, 16'h0080, M_READ, K_NONE, "R4 erase setup");
        unlock(M_READ, "R4");
        wr(19'h555, 16'h0010, M_BUSY, K_CHIP, "R4 chip erase");
        wr(19'h555, 16'h00B0, M_BUSY, K_NONE, "R9 no suspend in chip erase");
        done_pulse(M_READ);
        // R4: 0x10 at another address aborts
        unlock(M_READ, "R4");
        wr(19'h555, 16'h0080, M_READ, K_NONE, "R4");
        unlock(M_READ, "R4");
        wr(19'h123, 16'h0010, M_READ, K_NONE, "R4 wrong address");

        // R6 identifier mode
        unlock(M_READ, "R6");
        wr(19'h555, 16'h0090, M_ID, K_NONE, "R6 enter");
        wr(19'h555, 16'h00AA, M_ID, K_NONE, "R6 ignored");
        wr(19'h2AA, 16'h0055, M_ID, K_NONE, "R6 ignored");
        wr(19'h555, 16'h00F0, M_READ, K_NONE, "R6 R7 exit");

        // R7 reset forms
        unlock(M_READ, "R7");
        wr(19'h555, 16'h00F0, M_READ, K_NONE, "R7 three-cycle");
        wr(19'h555, 16'h00A0, M_READ, K_NONE, "R7 no setup");
        wr(19'h00400, 16'h0004, M_READ, K_NONE, "R7 no program");
        wr(19'h555, 16'h00AA, M_READ, K_NONE, "R7");
        wr(19'h7FF, 16'h00F0, M_READ, K_NONE, "R7 single abort");
        wr(19'h555, 16'h00A0, M_READ, K_NONE, "R7 no setup");
        wr(19'h00400, 16'h0004, M_READ, K_NONE, "R7 no program");

        // R8 wrong cycle aborts
        wr(19'h555, 16'h00AA, M_READ, K_NONE, "R8");
        wr(19'h555, 16'h0055, M_READ, K_NONE, "R8 wrong address");
        wr(19'h555, 16'h00A0, M_READ, K_NONE, "R8");
        wr(19'h00500, 16'h0005, M_READ, K_NONE, "R8 no program");

        // R10: resume/suspend outside their modes
        wr(19'h00000, 16'h0030, M_READ, K_NONE, "R10 resume in read");
        wr(19'h00000, 16'h00B0, M_READ, K_NONE, "R9 suspend in read");

        // R5 sector erase with two sectors
        unlock(M_READ, "R5");
        wr(19'h555, 16'h0080, M_READ, K_NONE, "R5");
        unlock(M_READ, "R5");
        wr(19'h10000, 16'h0030, M_READ, K_SECT, "R5 sector A");
        wr(19'h20000, 16'h0030, M_READ, K_SECT, "R5 sector B");
        base = pc;
        repeat (WIN - 1) @(posedge clk);
        exp_mode = M_BUSY;
        @(negedge clk);
        @(posedge clk);
        check_pulses(base, K_START, "R5 erase start");
        @(negedge clk);
        wr(19'h00000, 16'h0030, M_BUSY, K_NONE, "R10 resume while running");
        wr(19'h00000, 16'h00B0, M_SUSP, K_SUSP, "R9 suspend");
        wr(19'h00000, 16'h0030, M_BUSY, K_RES, "R10 resume");
        wr(19'h00000, 16'h00B0, M_SUSP, K_SUSP, "R9 suspend again");
        // R11 program from suspend
        unlock(M_SUSP, "R11");
        wr(19'h555, 16'h00A0, M_SUSP, K_NONE, "R11 setup");
        wr(19'h30010, 16'h0F0F, M_BUSY, K_PRG, "R11 program");
        done_pulse(M_SUSP);
        // R11 identifier from suspend
        unlock(M_SUSP, "R11");
        wr(19'h555, 16'h0090, M_ID, K_NONE, "R11 id");
        wr(19'h000, 16'h00F0, M_SUSP, K_NONE, "R11 id exit");
        // R8 abort from suspend, R9 erase refused from suspend
        wr(19'h555, 16'h00AA, M_SUSP, K_NONE, "R8");
        wr(19'h123, 16'h0055, M_SUSP, K_NONE, "R8 abort to suspend");
        unlock(M_SUSP, "R9");
        wr(19'h555, 16'h0080, M_SUSP, K_NONE, "R9 erase refused");
        wr(19'h000, 16'h00F0, M_SUSP, K_NONE, "R7 reset in suspend");
        wr(19'h000, 16'h0030, M_BUSY, K_RES, "R10 resume");
        done_pulse(M_READ);

        // R5 window aborted by another write
        unlock(M_READ, "R5");
        wr(19'h555, 16'h0080, M_READ, K_NONE, "R5");
        unlock(M_READ, "R5");
        wr(19'h30000, 16'h0030, M_READ, K_SECT, "R5 sector");
        wr(19'h000, 16'h00F0, M_READ, K_NONE, "R5 abort window");
        base = pc;
        repeat (WIN + 10) @(posedge clk);
        @(negedge clk);
        check_pulses(base, K_NONE, "R5 no erase start after abort");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule